// File: doc/BRIEF.md
# Legacy Memory Window Access Steering

This block decides, for every host access into the legacy address window between 768 KB and 1 MB (0xC0000 to 0xFFFFF), whether the access is served by main memory or passed on to a downstream legacy port. The window is cut into thirteen segments: twelve of 16 KB covering 0xC0000 to 0xEFFFF, and one of 64 KB covering 0xF0000 to 0xFFFFF. Each segment carries a two-bit attribute with one read-enable and one write-enable bit. A segment can therefore be disabled, read-only, write-only or fully mapped to memory.

A host access is presented with a 20-bit address, a write flag and a valid strobe. One clock later the block raises exactly one of two route outputs: memory or downstream. Software programs the thirteen attributes through seven byte-wide registers on a small configuration port. A lock input freezes the attribute registers until the next reset.

Top module: `lowmem_steer`

## Requirements
- R1: After reset every attribute is 00, every configuration register reads 0x00, and every access inside 0xC0000..0xFFFFF is routed downstream.
- R2: The cycle after a clock edge that samples `host_valid` high, exactly one of `route_mem` and `route_dn` is high. The cycle after an edge that samples `host_valid` low, both are low.
- R3: In each 2-bit attribute, bit 0 enables reads and bit 1 enables writes. A set bit sends that access direction to memory and a clear bit sends it downstream, so 00 means disabled, 01 read-only, 10 write-only and 11 both directions to memory.
- R4: The register at offset 0x80 holds the attribute of the 64 KB segment 0xF0000..0xFFFFF in bits [5:4].
- R5: The registers at offsets 0x81..0x86 each hold two 16 KB segment attributes: the lower segment in bits [1:0] and the next higher segment in bits [5:4]. Offset 0x81 covers 0xC0000..0xC7FFF, and each following offset covers the next 32 KB in ascending order up to 0xEFFFF.
- R6: Reserved bits read as zero and are not stored. These are bits [7:6] and [3:0] at offset 0x80, and bits [7:6] and [3:2] at offsets 0x81..0x86.
- R7: Any access whose address is below 0xC0000 is routed to memory, whatever the attribute contents.
- R8: A high `lock_set` sampled at a clock edge makes the lock sticky until reset. Configuration writes in later cycles leave every attribute unchanged.
- R9: A configuration write to an offset outside 0x80..0x86 changes nothing, and a read of such an offset returns 0x00.
- R10: `cfg_rdata` is combinational from `cfg_addr` and the register contents, with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| lock_set | input | 1 | Sets the sticky attribute lock |
| host_valid | input | 1 | Host access strobe |
| host_addr | input | 20 | Host access address |
| host_is_wr | input | 1 | 1 for a write access, 0 for a read |
| route_mem | output | 1 | Registered: previous access goes to main memory |
| route_dn | output | 1 | Registered: previous access goes downstream |

## Verification
The hardest case to reach is the interaction between the lock and segment decoding. A write that is blocked must leave every one of the thirteen fields untouched, and this can only be seen through reads and through routing of both directions in the affected segments. The bench first loads distinct patterns into all seven registers and checks every segment in both directions, including the edges at 0xBFFFF/0xC0000 and 0xEFFFF/0xF0000. It then sets the lock, writes opposite values, and checks again that both readback and routing are unchanged.

// File: rtl/lowmem_steer_pkg.sv
package lowmem_steer_pkg;
  localparam int unsigned ATTR_W  = 2;
  localparam int unsigned NUM_SEG = 13;
  localparam int unsigned NUM_REG = 7;
  localparam int unsigned SEG_IW  = 4;
  localparam int unsigned RD_BIT  = 0;
  localparam int unsigned WR_BIT  = 1;

  typedef logic [ATTR_W-1:0] attr_t;

  // register that holds segment g (segment NUM_SEG-1 is the 64 KB top one)
  function automatic int unsigned seg_reg(input int unsigned g);
    return (g == NUM_SEG - 1) ? 0 : (g / 2) + 1;
  endfunction

  // low bit position of segment g inside its register
  function automatic int unsigned seg_lsb(input int unsigned g);
    return (g == NUM_SEG - 1) ? 4 : ((g % 2) == 1 ? 4 : 0);
  endfunction
endpackage

// File: rtl/lowmem_rst_sync.sv
module lowmem_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/lowmem_attr_regs.sv
module lowmem_attr_regs
  import lowmem_steer_pkg::*;
#(
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  CFG_BASE = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 lock_set,
  output logic [DATA_W-1:0]    cfg_rdata,
  output attr_t [NUM_SEG-1:0]  attr_o
);
  localparam logic [CFG_AW-1:0] BASE = CFG_AW'(CFG_BASE);

  attr_t [NUM_SEG-1:0] attr_q, attr_d;
  logic                locked_q, locked_d;
  logic [CFG_AW-1:0]   rel;
  logic                hit;
  logic                wr_en;

  assign rel   = cfg_addr - BASE;
  assign hit   = (cfg_addr >= BASE) && (rel < CFG_AW'(NUM_REG));
  assign wr_en = cfg_wr && hit && !locked_q;

  // lock next state: sticky
  always_comb begin
    locked_d = locked_q;
    if (lock_set) locked_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= locked_d;
  end

  // one attribute field per segment
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int unsigned REG = seg_reg(g);
    localparam int unsigned LSB = seg_lsb(g);

    always_comb begin
      attr_d[g] = attr_q[g];
      if (wr_en && (rel == CFG_AW'(REG))) attr_d[g] = cfg_wdata[LSB +: ATTR_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 attr_q[g] <= '0;
      else if (attr_d[g] != attr_q[g]) attr_q[g] <= attr_d[g];
    end
  end

  // combinational readback, reserved bits stay zero
  always_comb begin
    cfg_rdata = '0;
    if (hit) begin
      for (int unsigned g = 0; g < NUM_SEG; g++) begin
        if (rel == CFG_AW'(seg_reg(g))) cfg_rdata[seg_lsb(g) +: ATTR_W] = attr_q[g];
      end
    end
  end

  assign attr_o = attr_q;

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(attr_q));
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] == 2'b00) && (cfg_rdata[3:2] == 2'b00));
  p_top_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == BASE) |-> (cfg_rdata[1:0] == 2'b00));
  p_bad_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (cfg_rdata == '0));
  p_bad_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit) |=> $stable(attr_q));
endmodule

// File: rtl/lowmem_seg_decode.sv
module lowmem_seg_decode
  import lowmem_steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [SEG_IW-1:0] seg_idx
);
  // window is the top quarter of the 1 MB space
  assign in_win = (addr[ADDR_W-1 -: 2] == 2'b11);

  always_comb begin
    if (addr[ADDR_W-3 -: 2] == 2'b11) seg_idx = SEG_IW'(NUM_SEG - 1);
    else                              seg_idx = addr[ADDR_W-3 -: SEG_IW];
  end

  logic unused_low;
  assign unused_low = ^addr[ADDR_W-3-SEG_IW:0];
endmodule

// File: rtl/lowmem_route_sel.sv
module lowmem_route_sel
  import lowmem_steer_pkg::*;
(
  input  logic                in_win,
  input  logic [SEG_IW-1:0]   seg_idx,
  input  logic                is_wr,
  input  attr_t [NUM_SEG-1:0] attr,
  output logic                to_mem
);
  attr_t sel;

  always_comb begin
    sel = '0;
    for (int unsigned g = 0; g < NUM_SEG; g++) begin
      if (seg_idx == SEG_IW'(g)) sel = attr[g];
    end
  end

  assign to_mem = !in_win || (is_wr ? sel[WR_BIT] : sel[RD_BIT]);
endmodule

// File: rtl/lowmem_steer.sv
module lowmem_steer
  import lowmem_steer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  CFG_BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              lock_set,
  input  logic              host_valid,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_is_wr,
  output logic              route_mem,
  output logic              route_dn
);
  logic                rst_n;
  attr_t [NUM_SEG-1:0] attr;
  logic                in_win;
  logic [SEG_IW-1:0]   seg_idx;
  logic                to_mem;
  logic                mem_q, mem_d, dn_q, dn_d;

  lowmem_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  lowmem_attr_regs #(
    .CFG_AW   (CFG_AW),
    .DATA_W   (DATA_W),
    .CFG_BASE (CFG_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lock_set  (lock_set),
    .cfg_rdata (cfg_rdata),
    .attr_o    (attr)
  );

  lowmem_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (host_addr),
    .in_win  (in_win),
    .seg_idx (seg_idx)
  );

  lowmem_route_sel u_sel (
    .in_win  (in_win),
    .seg_idx (seg_idx),
    .is_wr   (host_is_wr),
    .attr    (attr),
    .to_mem  (to_mem)
  );

  always_comb begin
    mem_d = 1'b0;
    dn_d  = 1'b0;
    if (host_valid) begin
      mem_d = to_mem;
      dn_d  = !to_mem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      mem_q <= mem_d;
      dn_q  <= dn_d;
    end
  end

  assign route_mem = mem_q;
  assign route_dn  = dn_q;

  p_route_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> (route_mem ^ route_dn));
  p_route_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |=> (!route_mem && !route_dn));
  p_outside_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && (host_addr[ADDR_W-1 -: 2] != 2'b11)) |=> route_mem);
endmodule

// File: tb/lowmem_steer_tb_top.sv
`timescale 1ns/1ps
module lowmem_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       cfg_wr;
  logic [7:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic       lock_set;
  logic       host_valid;
  logic [19:0] host_addr;
  logic       host_is_wr;
  logic       route_mem, route_dn;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] m_reg [7];
  bit         m_locked;

  always #2.5 clk = ~clk;

  lowmem_steer dut_i (
    .clk(clk), .rst_ni(rst_ni), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_set(lock_set),
    .host_valid(host_valid), .host_addr(host_addr), .host_is_wr(host_is_wr),
    .route_mem(route_mem), .route_dn(route_dn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected route from the requirement text (R3, R4, R5, R7)
  function automatic bit exp_mem(input logic [19:0] a, input bit wr);
    logic [1:0] f;
    int s;
    if (a < 20'hC0000) return 1'b1;
    if (a >= 20'hF0000) f = m_reg[0][5:4];
    else begin
      s = int'((a - 20'hC0000) >> 14);
      f = (s % 2 == 1) ? m_reg[1 + s/2][5:4] : m_reg[1 + s/2][1:0];
    end
    return wr ? f[1] : f[0];
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!m_locked && a >= 8'h80 && a <= 8'h86)
      m_reg[a - 8'h80] = d & ((a == 8'h80) ? 8'h30 : 8'h33);
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    cfg_addr = a;
    #0.5;
    e = (a >= 8'h80 && a <= 8'h86) ? m_reg[a - 8'h80] : 8'h00;
    chk(cfg_rdata == e, req, $sformatf("read offset %0h", a), cfg_rdata, e);
  endtask

  task automatic host_chk(input logic [19:0] a, input bit wr, input string req);
    bit e;
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; host_is_wr = wr;
    @(negedge clk);
    host_valid = 1'b0;
    e = exp_mem(a, wr);
    chk(route_mem == e && route_dn == !e, req,
        $sformatf("route addr %0h wr %0d", a, wr), {route_mem, route_dn}, {e, !e});
    @(negedge clk);
    chk(!route_mem && !route_dn, "R2", "idle route", {route_mem, route_dn}, 2'b00);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 7; i++) read_chk(8'h80 + 8'(i), "R1");
    host_chk(20'hC0000, 1'b0, "R1");
    host_chk(20'hC0000, 1'b1, "R1");
    host_chk(20'hFFFFF, 1'b0, "R1");
    host_chk(20'hE8000, 1'b1, "R1");
  endtask

  task automatic t_top_seg;
    for (int enc = 0; enc < 4; enc++) begin
      cfg_write(8'h80, 8'(enc << 4));
      read_chk(8'h80, "R4");
      host_chk(20'hF8000, 1'b0, "R3");
      host_chk(20'hF8000, 1'b1, "R3");
    end
  endtask

  task automatic t_low_segs;
    cfg_write(8'h80, 8'h10);
    cfg_write(8'h81, 8'h21);
    cfg_write(8'h82, 8'h03);
    cfg_write(8'h83, 8'h12);
    cfg_write(8'h84, 8'h30);
    cfg_write(8'h85, 8'h31);
    cfg_write(8'h86, 8'h02);
    for (int i = 1; i < 7; i++) read_chk(8'h80 + 8'(i), "R10");
    for (int s = 0; s < 12; s++) begin
      host_chk(20'hC0000 + 20'(s * 20'h4000) + 20'h1234, 1'b0, "R5");
      host_chk(20'hC0000 + 20'(s * 20'h4000) + 20'h1234, 1'b1, "R5");
    end
    host_chk(20'hEFFFF, 1'b1, "R5");
    host_chk(20'hF0000, 1'b0, "R4");
    host_chk(20'hC0000, 1'b0, "R5");
  endtask

  task automatic t_reserved;
    cfg_write(8'h80, 8'hFF);
    read_chk(8'h80, "R6");
    cfg_write(8'h83, 8'hFF);
    read_chk(8'h83, "R6");
    cfg_write(8'h86, 8'hCC);
    read_chk(8'h86, "R6");
    host_chk(20'hEC000, 1'b0, "R6");
  endtask

  task automatic t_outside;
    for (int i = 0; i < 7; i++) cfg_write(8'h80 + 8'(i), 8'h00);
    host_chk(20'hBFFFF, 1'b0, "R7");
    host_chk(20'hBFFFF, 1'b1, "R7");
    host_chk(20'h00000, 1'b1, "R7");
    host_chk(20'hA0000, 1'b0, "R7");
  endtask

  task automatic t_bad_offset;
    cfg_write(8'h82, 8'h11);
    cfg_write(8'h7F, 8'hFF);
    cfg_write(8'h87, 8'hFF);
    read_chk(8'h7F, "R9");
    read_chk(8'h87, "R9");
    read_chk(8'h00, "R9");
    for (int i = 0; i < 7; i++) read_chk(8'h80 + 8'(i), "R9");
  endtask

  task automatic t_lock;
    cfg_write(8'h80, 8'h30);
    cfg_write(8'h84, 8'h21);
    @(negedge clk);
    lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
    m_locked = 1'b1;
    for (int i = 0; i < 7; i++) cfg_write(8'h80 + 8'(i), 8'hDE);
    for (int i = 0; i < 7; i++) read_chk(8'h80 + 8'(i), "R8");
    host_chk(20'hF0000, 1'b1, "R8");
    host_chk(20'hD8000, 1'b0, "R8");
    host_chk(20'hDC000, 1'b1, "R8");
    repeat (3) @(negedge clk);
    cfg_write(8'h80, 8'h00);
    read_chk(8'h80, "R8");
  endtask

  initial begin
    rst_ni = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    lock_set = 1'b0; host_valid = 1'b0; host_addr = '0; host_is_wr = 1'b0;
    m_locked = 1'b0;
    for (int i = 0; i < 7; i++) m_reg[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(!route_mem && !route_dn, "R1", "route after reset", {route_mem, route_dn}, 2'b00);
    t_reset();
    t_top_seg();
    t_low_segs();
    t_reserved();
    t_outside();
    t_bad_offset();
    t_lock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule